// File: doc/BRIEF.md
# Eight-Pin GPIO Controller with Interrupt Sensing

The block is a register-mapped controller for eight general-purpose pins. A host reaches it over a single-cycle register bus: an address, a write strobe, a byte of write data, and read data returned combinationally in the same cycle. Each pin has its own direction bit. Data reads and writes take a per-pin mask from the address, so software can drive or sample any subset of pins without a read-modify-write sequence.

Every pin passes through a two-flop synchroniser. A per-pin sense machine then watches the pin. It can report a level (active-high or active-low), a single edge (rising or falling) or any transition. Level conditions are reported live. Edge events are held until software clears them by writing ones to the clear register. Raw status, masked status and a single combined interrupt output let an interrupt handler find and clear pending pins.

Each pin's sense machine has two states: `PIN_IDLE` (no edge event held) and `PIN_PEND` (an edge event is held). Its transitions are:
- `PIN_IDLE` to `PIN_PEND` on `catch`, a qualifying edge while the pin is in edge mode.
- `PIN_PEND` to `PIN_IDLE` on `release`, a clear write with a one for that pin in a cycle with no new qualifying edge.
- Otherwise the machine stays in its current state (`hold`).

Top module: `gpio8_irq_ctrl`

## Requirements
- R1: After reset, every register reads zero, `pin_oe` and `pin_out` are all zero, and `irq` is low.
- R2: The direction register sits at offset 0x400. Bit n set to 1 makes pin n an output, and `pin_oe[n]` follows that bit from the cycle after the write.
- R3: A write to any offset below 0x400 is a data write, and address bit n+2 selects pin n. The write updates the output value only for pins that are both selected and set as outputs at the time of the write. All other bits keep their values.
- R4: A read from any offset below 0x400 returns data only for pins whose address bit n+2 is 1, and returns 0 for unselected pins. A selected output pin returns its driven value. A selected input pin returns its synchronised input.
- R5: A pin input change becomes visible in data reads after the second rising clock edge that follows it.
- R6: Sense register 0x404 bit = 1 selects level mode for that pin. In level mode, raw status (0x414) is 1 while the synchronised pin equals the event-register (0x40C) bit. This status is not latched, and a clear write does not change it.
- R7: Sense bit = 0 with both-edges (0x408) bit = 0 selects single-edge mode. Event bit 1 means rising and 0 means falling. The raw status bit becomes 1 after the third rising edge that follows the pin change, and it is still 0 after the second.
- R8: In edge mode with the both-edges bit set to 1, either transition sets raw status, and the event bit has no effect.
- R9: Writing 1 to bit n of the clear register (0x41C) clears the held edge status of pin n, and a 0 bit leaves it unchanged. If a qualifying edge lands in the same cycle as the clear, the status stays set.
- R10: Masked status (0x418) equals raw status AND the enable register (0x410). `irq` is 1 exactly when any masked status bit is 1.
- R11: Reads of 0x41C and of unmapped offsets return 0. Writes to 0x414 and 0x418 have no effect.
- R12: The direction, sense, both-edges, event and enable registers read back the last value written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 12 | Register byte address |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 8 | Write data, one bit per pin |
| bus_rdata | output | 8 | Combinational read data |
| pin_in | input | 8 | Pin input levels (asynchronous) |
| pin_out | output | 8 | Output value register |
| pin_oe | output | 8 | Output enables (direction) |
| irq | output | 1 | Combined interrupt |

## Verification
Register reads are due in the same cycle the address is presented. Register writes and `pin_oe` take effect after one rising edge. A pin change reaches data reads and level status after two edges, and a held edge status after three. The bench applies pin changes on the falling clock edge and counts rising edges explicitly before each read. It checks edge status both after the second edge, where it must still be 0, and after the third, where it must be set. It also places a clear write on exactly the edge where the event is caught, to confirm that the event wins.

// File: rtl/gpio8_pkg.sv
package gpio8_pkg;

    // Register byte offsets
    localparam int unsigned OFS_DIR   = 32'h400;
    localparam int unsigned OFS_SENSE = 32'h404;
    localparam int unsigned OFS_BOTH  = 32'h408;
    localparam int unsigned OFS_EVT   = 32'h40C;
    localparam int unsigned OFS_IEN   = 32'h410;
    localparam int unsigned OFS_RAW   = 32'h414;
    localparam int unsigned OFS_MSK   = 32'h418;
    localparam int unsigned OFS_CLR   = 32'h41C;

    // Per-pin edge-capture state
    typedef enum logic {
        PIN_IDLE = 1'b0,
        PIN_PEND = 1'b1
    } pin_st_t;

endpackage

// File: rtl/gpio8_sync.sv
module gpio8_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_now,
    output logic [W-1:0] sync_prev
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q    <= '0;
            sync_now  <= '0;
            sync_prev <= '0;
        end else begin
            meta_q    <= async_in;
            sync_now  <= meta_q;
            sync_prev <= sync_now;
        end
    end
endmodule

// File: rtl/gpio8_pin_sense.sv
module gpio8_pin_sense
    import gpio8_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_now,
    input  logic lvl_prev,
    input  logic cfg_level,
    input  logic cfg_both,
    input  logic cfg_pol,
    input  logic clr_hit,
    output logic raw_sts
);
    pin_st_t st_q, st_d;
    logic rise_w, fall_w, catch_w;

    assign rise_w = lvl_now & ~lvl_prev;
    assign fall_w = ~lvl_now & lvl_prev;

    always_comb begin
        if (cfg_level)
            catch_w = 1'b0;
        else if (cfg_both)
            catch_w = rise_w | fall_w;
        else
            catch_w = cfg_pol ? rise_w : fall_w;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= PIN_IDLE;
        else        st_q <= st_d;
    end

    // Next state: catch wins over release
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            PIN_IDLE: if (catch_w) st_d = PIN_PEND;
            PIN_PEND: if (clr_hit && !catch_w) st_d = PIN_IDLE;
            default:  st_d = PIN_IDLE;
        endcase
    end

    // Output: live level condition, or held edge state
    always_comb begin
        if (cfg_level) raw_sts = (lvl_now == cfg_pol);
        else           raw_sts = (st_q == PIN_PEND);
    end
endmodule

// File: rtl/gpio8_regfile.sv
module gpio8_regfile
    import gpio8_pkg::*;
#(
    parameter int NPIN   = 8,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [NPIN-1:0]   bus_wdata,
    output logic [NPIN-1:0]   bus_rdata,
    input  logic [NPIN-1:0]   pin_sync,
    input  logic [NPIN-1:0]   raw_sts,
    output logic [NPIN-1:0]   dir_q,
    output logic [NPIN-1:0]   dout_q,
    output logic [NPIN-1:0]   sense_q,
    output logic [NPIN-1:0]   both_q,
    output logic [NPIN-1:0]   evt_q,
    output logic [NPIN-1:0]   ien_q,
    output logic [NPIN-1:0]   clr_mask
);
    localparam logic [ADDR_W-1:0] A_DIR   = ADDR_W'(OFS_DIR);
    localparam logic [ADDR_W-1:0] A_SENSE = ADDR_W'(OFS_SENSE);
    localparam logic [ADDR_W-1:0] A_BOTH  = ADDR_W'(OFS_BOTH);
    localparam logic [ADDR_W-1:0] A_EVT   = ADDR_W'(OFS_EVT);
    localparam logic [ADDR_W-1:0] A_IEN   = ADDR_W'(OFS_IEN);
    localparam logic [ADDR_W-1:0] A_RAW   = ADDR_W'(OFS_RAW);
    localparam logic [ADDR_W-1:0] A_MSK   = ADDR_W'(OFS_MSK);
    localparam logic [ADDR_W-1:0] A_CLR   = ADDR_W'(OFS_CLR);

    logic              is_data;
    logic [NPIN-1:0]   sel_mask;
    logic [NPIN-1:0]   wr_bits;

    assign is_data  = (bus_addr < A_DIR);
    assign sel_mask = bus_addr[NPIN+1:2];
    assign wr_bits  = sel_mask & dir_q;
    assign clr_mask = (bus_we && bus_addr == A_CLR) ? bus_wdata : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q   <= '0;
            dout_q  <= '0;
            sense_q <= '0;
            both_q  <= '0;
            evt_q   <= '0;
            ien_q   <= '0;
        end else if (bus_we) begin
            if (is_data)
                dout_q <= (dout_q & ~wr_bits) | (bus_wdata & wr_bits);
            else if (bus_addr == A_DIR)   dir_q   <= bus_wdata;
            else if (bus_addr == A_SENSE) sense_q <= bus_wdata;
            else if (bus_addr == A_BOTH)  both_q  <= bus_wdata;
            else if (bus_addr == A_EVT)   evt_q   <= bus_wdata;
            else if (bus_addr == A_IEN)   ien_q   <= bus_wdata;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (is_data) begin
            bus_rdata = ((dir_q & dout_q) | (~dir_q & pin_sync)) & sel_mask;
        end else begin
            case (bus_addr)
                A_DIR:   bus_rdata = dir_q;
                A_SENSE: bus_rdata = sense_q;
                A_BOTH:  bus_rdata = both_q;
                A_EVT:   bus_rdata = evt_q;
                A_IEN:   bus_rdata = ien_q;
                A_RAW:   bus_rdata = raw_sts;
                A_MSK:   bus_rdata = raw_sts & ien_q;
                default: bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/gpio8_irq_ctrl.sv
module gpio8_irq_ctrl #(
    parameter int NPIN   = 8,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [NPIN-1:0]   bus_wdata,
    output logic [NPIN-1:0]   bus_rdata,
    input  logic [NPIN-1:0]   pin_in,
    output logic [NPIN-1:0]   pin_out,
    output logic [NPIN-1:0]   pin_oe,
    output logic              irq
);
    logic [NPIN-1:0] s_now, s_prev;
    logic [NPIN-1:0] dir_q, dout_q, sense_q, both_q, evt_q, ien_q, clr_mask;
    logic [NPIN-1:0] raw_sts;

    gpio8_sync #(.W(NPIN)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .async_in  (pin_in),
        .sync_now  (s_now),
        .sync_prev (s_prev)
    );

    gpio8_regfile #(.NPIN(NPIN), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_sync  (s_now),
        .raw_sts   (raw_sts),
        .dir_q     (dir_q),
        .dout_q    (dout_q),
        .sense_q   (sense_q),
        .both_q    (both_q),
        .evt_q     (evt_q),
        .ien_q     (ien_q),
        .clr_mask  (clr_mask)
    );

    for (genvar g = 0; g < NPIN; g++) begin : g_pin
        gpio8_pin_sense u_sense (
            .clk       (clk),
            .rst_n     (rst_n),
            .lvl_now   (s_now[g]),
            .lvl_prev  (s_prev[g]),
            .cfg_level (sense_q[g]),
            .cfg_both  (both_q[g]),
            .cfg_pol   (evt_q[g]),
            .clr_hit   (clr_mask[g]),
            .raw_sts   (raw_sts[g])
        );
    end

    assign pin_oe  = dir_q;
    assign pin_out = dout_q;
    assign irq     = |(raw_sts & ien_q);
endmodule

// File: rtl/gpio8_irq_ctrl_chk.sv
module gpio8_irq_ctrl_chk #(
    parameter int NPIN   = 8,
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [NPIN-1:0]   bus_rdata,
    input logic [NPIN-1:0]   pin_out,
    input logic [NPIN-1:0]   pin_oe,
    input logic              irq
);
    localparam logic [ADDR_W-1:0] C_DIR = ADDR_W'(32'h400);
    localparam logic [ADDR_W-1:0] C_MSK = ADDR_W'(32'h418);
    localparam logic [ADDR_W-1:0] C_CLR = ADDR_W'(32'h41C);

    // R2
    oe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && bus_addr == C_DIR) |=> $stable(pin_oe));

    // R3
    dout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && bus_addr < C_DIR) |=> $stable(pin_out));

    // R4
    unsel_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr < C_DIR) |-> ((bus_rdata & ~bus_addr[NPIN+1:2]) == '0));

    // R10
    irq_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == C_MSK) |-> ((bus_rdata != '0) == irq));

    // R11
    clr_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == C_CLR) |-> (bus_rdata == '0));
endmodule

bind gpio8_irq_ctrl gpio8_irq_ctrl_chk #(.NPIN(NPIN), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_rdata (bus_rdata),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .irq       (irq)
);

// File: tb/gpio8_irq_ctrl_tb.sv
module gpio8_irq_ctrl_tb;
    localparam logic [11:0] A_DIR = 12'h400, A_SEN = 12'h404, A_BTH = 12'h408,
                            A_EVT = 12'h40C, A_IEN = 12'h410, A_RAW = 12'h414,
                            A_MSK = 12'h418, A_CLR = 12'h41C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [7:0]  pin_in = '0;
    logic [7:0]  pin_out, pin_oe;
    logic        irq;
    int          nchk = 0;
    int          nfail = 0;

    always #5 clk = ~clk;

    gpio8_irq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        nchk++;
        if (got !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(posedge clk);
        #1 bus_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic set_pins(input logic [7:0] v);
        @(negedge clk);
        pin_in = v;
    endtask

    initial begin
        #2_000_000;
        nfail++;
        $display("FAIL watchdog all-reqs actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        logic [7:0] d;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        foreach (d[i]) begin end
        for (int a = 0; a < 8; a++) begin
            rd(12'h400 + 12'(a * 4), d);
            chk("R1 reg reset", d, 8'h00);
        end
        chk("R1 pin_oe", pin_oe, 8'h00);
        chk("R1 pin_out", pin_out, 8'h00);
        chk("R1 irq", {7'd0, irq}, 8'h00);

        // R12 readback
        wr(A_SEN, 8'h5A); wr(A_BTH, 8'hC3); wr(A_EVT, 8'h3C); wr(A_IEN, 8'h81);
        rd(A_SEN, d); chk("R12 sense", d, 8'h5A);
        rd(A_BTH, d); chk("R12 both", d, 8'hC3);
        rd(A_EVT, d); chk("R12 event", d, 8'h3C);
        rd(A_IEN, d); chk("R12 enable", d, 8'h81);
        wr(A_SEN, 0); wr(A_BTH, 0); wr(A_EVT, 0); wr(A_IEN, 0);

        // R2 direction
        wr(A_DIR, 8'h0F);
        #1 chk("R2 pin_oe", pin_oe, 8'h0F);
        rd(A_DIR, d); chk("R12 dir", d, 8'h0F);

        // R3 masked write: only selected output pins change
        wr(12'h3FC, 8'hFF);
        #1 chk("R3 all-mask write", pin_out, 8'h0F);
        wr(12'h008, 8'h00);
        #1 chk("R3 single pin write", pin_out, 8'h0D);
        wr(12'h3FC, 8'h00);
        wr(12'h3FC, 8'hFF);
        #1 chk("R3 rewrite", pin_out, 8'h0F);
        wr(12'h008, 8'h00);

        // R5 synchroniser latency
        set_pins(8'hA0);
        @(posedge clk);
        #1 chk("R5 after 1 edge", bus_rdata, 8'h00);
        @(posedge clk);
        rd(12'h3FC, d); chk("R5 after 2 edges", d, 8'hAD);

        // R4 mask sweep
        for (int k = 0; k < 256; k++) begin
            rd(12'(k << 2), d);
            chk("R4 masked read", d, 8'hAD & 8'(k));
        end

        // R11 unmapped, clear read, status writes ignored
        rd(12'h420, d); chk("R11 unmapped", d, 8'h00);
        rd(12'h7FC, d); chk("R11 unmapped high", d, 8'h00);
        rd(A_CLR, d); chk("R11 clear read", d, 8'h00);
        wr(A_RAW, 8'hFF); rd(A_RAW, d); chk("R11 raw write ignored", d, 8'h00);
        wr(A_MSK, 8'hFF); rd(A_MSK, d); chk("R11 masked write ignored", d, 8'h00);

        // Sense sweep: pin p, mode m (0 lvl-hi, 1 lvl-lo, 2 rise, 3 fall, 4 both)
        wr(A_DIR, 8'h00);
        for (int p = 0; p < 8; p++) begin
            for (int m = 0; m < 5; m++) begin
                logic [7:0] b, e_pre, e_rise, e_clr, e_fall;
                b = 8'(1 << p);
                wr(A_SEN, (m < 2) ? b : 8'h00);
                wr(A_BTH, (m == 4) ? b : 8'h00);
                wr(A_EVT, (m == 0 || m == 2) ? b : 8'h00);
                wr(A_IEN, b);
                set_pins(8'h00);
                repeat (4) @(posedge clk);
                wr(A_CLR, 8'hFF);
                e_pre  = (m == 0) ? b : 8'h00;
                e_rise = (m == 0 || m == 2 || m == 4) ? b : 8'h00;
                e_clr  = (m == 0) ? b : 8'h00;
                e_fall = (m == 1 || m == 3 || m == 4) ? b : 8'h00;
                set_pins(b);
                repeat (2) @(posedge clk);
                rd(A_RAW, d); chk("R6/R7 status after 2 edges", d, e_pre);
                @(posedge clk);
                rd(A_RAW, d); chk("R6/R7/R8 status after rise", d, e_rise);
                rd(A_MSK, d); chk("R10 masked status", d, e_rise);
                chk("R10 irq", {7'd0, irq}, {7'd0, e_rise != 0});
                wr(A_CLR, 8'hFF);
                rd(A_RAW, d); chk("R9/R6 status after clear", d, e_clr);
                set_pins(8'h00);
                repeat (3) @(posedge clk);
                rd(A_RAW, d); chk("R6/R7/R8 status after fall", d, e_fall);
                wr(A_CLR, ~b);
                rd(A_RAW, d); chk("R9 zero bits keep status", d, e_fall);
                wr(A_IEN, 8'h00);
                rd(A_MSK, d); chk("R10 disabled masked", d, 8'h00);
                chk("R10 disabled irq", {7'd0, irq}, 8'h00);
            end
        end

        // R9 edge caught in the same cycle as clear: status stays
        wr(A_SEN, 8'h00); wr(A_BTH, 8'h00); wr(A_EVT, 8'h04);
        wr(A_CLR, 8'hFF);
        set_pins(8'h04);
        repeat (2) @(posedge clk);
        @(negedge clk);
        bus_addr = A_CLR; bus_we = 1'b1; bus_wdata = 8'hFF;
        @(posedge clk);
        #1 bus_we = 1'b0;
        rd(A_RAW, d); chk("R9 catch beats clear", d, 8'h04);
        wr(A_CLR, 8'h04);
        rd(A_RAW, d); chk("R9 clear after collision", d, 8'h00);

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule